// File: doc/BRIEF.md
# Two-Wire Write-Only 24-Bit Word Loader

This block is a write-only target on a two-wire serial bus (I2C style). A fast system clock oversamples the bus clock and data lines. Bus START and STOP conditions frame each transfer. After a START, the block takes in an address byte. If the byte is one of its own write addresses, the block acknowledges it. It then collects the data bytes that follow in groups of three. Each group becomes a 24-bit word, which appears on a parallel output together with a single-cycle strobe.

A 2-bit strap input chooses which of four write addresses the block answers to: 0xC0, 0xC2, 0xC4 or 0xC6. Each word is released as soon as its third byte has been shifted in. The block does not wait for STOP to do this. Every new START restarts the byte grouping, so a group that was left unfinished is dropped.

The data line is never driven high. The acknowledge is an open-drain pull-down enable, and surrounding logic turns it into a real pad.

Top module: `i2c_word_loader`

States of the controller:
- IDLE: waiting for a START.
- ADDR: shifting in the address byte.
- ADDR_ACK: acknowledging a matched address.
- DATA: shifting in a data byte.
- DATA_ACK: acknowledging a data byte.
- IGNORE: the address did not match; the block waits for the next START.

Transitions between states:
- From any state, a START goes to ADDR.
- From any state other than a START, a STOP goes to IDLE.
- ADDR goes to ADDR_ACK when the eighth bit completes and the address matches. On a mismatch it goes to IGNORE.
- ADDR_ACK goes to DATA when the ninth clock falls.
- DATA goes to DATA_ACK when the eighth bit completes.
- DATA_ACK goes back to DATA when the ninth clock falls.

## Requirements
- R1: While reset is held and right after it is released, `sda_pull_o` and `word_valid_o` are 0 and `word_o` is 0.
- R2: A falling data line while the bus clock is high is a START. A START is recognised in any state, including in the middle of a byte, and the next eight bits are then treated as a new address byte.
- R3: Address bits arrive MSB first. The byte equals 0xC0 plus two times `addr_sel_i` (bit 0, the read/write bit, is 0). When it matches, the data line is pulled low through the whole ninth clock pulse.
- R4: If the address byte does not match, which includes any byte with bit 0 set to 1, no acknowledge is given. All following bytes are then neither acknowledged nor committed until the next START.
- R5: Each data byte after a matched address is acknowledged by pulling the data line low during its ninth clock pulse.
- R6: Data bytes are received MSB first. Every three consecutive data bytes form one word: the first byte goes to bits 23:16, the second to bits 15:8 and the third to bits 7:0. The word is driven on `word_o` with a `word_valid_o` pulse that lasts exactly one cycle. This happens after the third byte's eighth bit and before its acknowledge completes, with no STOP needed. Several words may follow one another within one transfer. `word_o` changes only together with the strobe.
- R7: A repeated START discards a partially received word. Grouping then restarts at the first data byte after the new matched address.
- R8: A rising data line while the bus clock is high is a STOP. After a STOP, bytes clocked without a new START are not acknowledged and produce no word.
- R9: The pull-down is released within a few system cycles after the ninth clock pulse falls, before the next rising edge of the bus clock. It only changes while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel_i | input | 2 | Strap that selects the write address 0xC0 + 2*value |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls the data line low |
| word_o | output | 24 | Last committed word |
| word_valid_o | output | 1 | One-cycle strobe marking a new `word_o` |

## Verification
A bit counter that is off by one would move the acknowledge into the wrong clock pulse. Because the acknowledge is sampled in the middle of the ninth high phase, this shows up in the very first byte. A byte counter that is off, or one that is not cleared by a repeated START, commits a word built from the wrong bytes or at the wrong byte. The scoreboard reports this at the first strobe, or it reports a missing strobe once the transfer ends. A controller that does not properly leave IGNORE or IDLE shows as a stray pull-down or an unexpected strobe during a byte that should be ignored.

// File: rtl/wl_pkg.sv
package wl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } wl_state_e;
endpackage

// File: rtl/wl_sync.sv
module wl_sync #(
    parameter int          W       = 2,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/wl_bus_events.sv
module wl_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        scl_rise  = scl_s && !scl_q;
        scl_fall  = !scl_s && scl_q;
        start_evt = scl_s && scl_q && sda_q && !sda_s;
        stop_evt  = scl_s && scl_q && !sda_q && sda_s;
    end
endmodule

// File: rtl/wl_byte_fsm.sv
module wl_byte_fsm
    import wl_pkg::*;
#(
    parameter int              BYTE_W     = 8,
    parameter int              WORD_BYTES = 3,
    parameter int              SEL_W      = 2,
    parameter logic [BYTE_W-1:0] ADDR_BASE = 8'hC0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         scl_rise,
    input  logic                         scl_fall,
    input  logic                         start_evt,
    input  logic                         stop_evt,
    input  logic                         sda_level,
    input  logic [SEL_W-1:0]             addr_sel,
    output logic                         sda_pull,
    output logic [WORD_BYTES*BYTE_W-1:0] word,
    output logic                         word_valid,
    output wl_state_e                    state
);
    localparam int WORD_W = WORD_BYTES * BYTE_W;
    localparam int BIT_CW = $clog2(BYTE_W + 1);
    localparam int BYTE_CW = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;

    wl_state_e            state_n;
    logic [BIT_CW-1:0]    bit_cnt;
    logic [BYTE_CW-1:0]   byte_cnt;
    logic [BYTE_W-1:0]    shreg;
    logic [WORD_W-1:0]    word_sr;
    logic                 byte_done;
    logic                 addr_hit;
    logic [BYTE_W-1:0]    own_addr;

    always_comb begin
        own_addr  = ADDR_BASE | (BYTE_W'(addr_sel) << 1);
        addr_hit  = (shreg == own_addr);
        byte_done = scl_fall && (bit_cnt == BIT_CW'(BYTE_W));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next-state logic
    always_comb begin
        state_n = state;
        if (start_evt) begin
            state_n = ST_ADDR;
        end else if (stop_evt) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: state_n = state;
                ST_ADDR:     if (byte_done) state_n = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall)  state_n = ST_DATA;
                ST_DATA:     if (byte_done) state_n = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall)  state_n = ST_DATA;
                default:     state_n = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            byte_cnt   <= '0;
            shreg      <= '0;
            word_sr    <= '0;
            word       <= '0;
            word_valid <= 1'b0;
            sda_pull   <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (start_evt) begin
                bit_cnt  <= '0;
                byte_cnt <= '0;
                sda_pull <= 1'b0;
            end else if (stop_evt) begin
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_DATA: begin
                        if (scl_rise && bit_cnt < BIT_CW'(BYTE_W)) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_level};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                        if (byte_done) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR) begin
                                sda_pull <= addr_hit;
                            end else begin
                                sda_pull <= 1'b1;
                                word_sr  <= {word_sr[WORD_W-BYTE_W-1:0], shreg};
                                if (byte_cnt == BYTE_CW'(WORD_BYTES - 1)) begin
                                    word       <= {word_sr[WORD_W-BYTE_W-1:0], shreg};
                                    word_valid <= 1'b1;
                                    byte_cnt   <= '0;
                                end else begin
                                    byte_cnt <= byte_cnt + 1'b1;
                                end
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_DATA_ACK: begin
                        if (scl_fall) sda_pull <= 1'b0;
                    end
                    default: sda_pull <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_word_loader.sv
module i2c_word_loader
    import wl_pkg::*;
#(
    parameter int                BYTE_W      = 8,
    parameter int                WORD_BYTES  = 3,
    parameter int                SEL_W       = 2,
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] ADDR_BASE   = 8'hC0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         scl_i,
    input  logic                         sda_i,
    input  logic [SEL_W-1:0]             addr_sel_i,
    output logic                         sda_pull_o,
    output logic [WORD_BYTES*BYTE_W-1:0] word_o,
    output logic                         word_valid_o
);
    logic [1:0] bus_s;
    logic       scl_rise, scl_fall, start_evt, stop_evt;
    wl_state_e  fsm_state;

    wl_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({scl_i, sda_i}),
        .sync_o (bus_s)
    );

    wl_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (bus_s[1]),
        .sda_s    (bus_s[0]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt)
    );

    wl_byte_fsm #(
        .BYTE_W    (BYTE_W),
        .WORD_BYTES(WORD_BYTES),
        .SEL_W     (SEL_W),
        .ADDR_BASE (ADDR_BASE)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .sda_level (bus_s[0]),
        .addr_sel  (addr_sel_i),
        .sda_pull  (sda_pull_o),
        .word      (word_o),
        .word_valid(word_valid_o),
        .state     (fsm_state)
    );
endmodule

// File: rtl/wl_checker.sv
module wl_checker
    import wl_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_pull_o,
    input logic [WORD_W-1:0] word_o,
    input logic              word_valid_o,
    input wl_state_e         state
);
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |=> !word_valid_o) else $error("strobe longer than one cycle"); // R6

    AST_WORD_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_o) |-> word_valid_o) else $error("word changed without strobe"); // R6

    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_i) else $error("pull changed while bus clock high"); // R9

    AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> (!sda_pull_o && !word_valid_o)) else $error("activity while ignoring"); // R4

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!sda_pull_o && !word_valid_o)) else $error("activity while idle"); // R8
endmodule

bind i2c_word_loader wl_checker #(.WORD_W(WORD_BYTES*BYTE_W)) u_wl_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_i),
    .sda_pull_o  (sda_pull_o),
    .word_o      (word_o),
    .word_valid_o(word_valid_o),
    .state       (fsm_state)
);

// File: tb/i2c_word_loader_bench.sv
module i2c_word_loader_bench;
    localparam int H = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_host = 1'b1;
    logic [1:0]  addr_sel = 2'd0;
    logic        sda_pull_o;
    logic [23:0] word_o;
    logic        word_valid_o;
    logic        sda_line;

    int checks = 0;
    int errors = 0;
    logic [23:0] exp_q [$];

    assign sda_line = sda_host & ~sda_pull_o;

    always #4 clk = ~clk;

    i2c_word_loader u_i2c_word_loader (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .addr_sel_i  (addr_sel),
        .sda_pull_o  (sda_pull_o),
        .word_o      (word_o),
        .word_valid_o(word_valid_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_host = 1'b1; hold(H);
        scl = 1'b1;      hold(H);
        sda_host = 1'b0; hold(H);
        scl = 1'b0;      hold(4);
    endtask

    task automatic bus_stop();
        scl = 1'b0;      hold(4);
        sda_host = 1'b0; hold(H);
        scl = 1'b1;      hold(H);
        sda_host = 1'b1; hold(H);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        logic acked;
        scl = 1'b0; hold(4);
        for (int i = 7; i >= 0; i--) begin
            sda_host = b[i]; hold(H);
            scl = 1'b1;      hold(H);
            scl = 1'b0;      hold(4);
        end
        sda_host = 1'b1; hold(H);
        scl = 1'b1;      hold(H/2);
        acked = (sda_line == 1'b0);
        check(acked == exp_ack, req, 32'(acked), 32'(exp_ack));
        hold(H/2);
        scl = 1'b0;      hold(H/2);
        check(sda_pull_o == 1'b0, "R9", 32'(sda_pull_o), 32'd0);
    endtask

    task automatic send_word(input logic [23:0] w);
        exp_q.push_back(w);
        send_byte(w[23:16], 1'b1, "R5");
        send_byte(w[15:8],  1'b1, "R5");
        send_byte(w[7:0],   1'b1, "R5");
        check(exp_q.size() == 0, "R6 commit before STOP", 32'(exp_q.size()), 32'd0);
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        #1;
        if (rst_n && word_valid_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected strobe", {8'd0, word_o}, 32'd0);
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                check(word_o == e, "R6 word value", {8'd0, word_o}, {8'd0, e});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 32'd0, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        hold(5);
        check(sda_pull_o == 1'b0,   "R1 pull", 32'(sda_pull_o), 32'd0);
        check(word_valid_o == 1'b0, "R1 strobe", 32'(word_valid_o), 32'd0);
        check(word_o == 24'd0,      "R1 word", {8'd0, word_o}, 32'd0);
        rst_n = 1'b1;
        hold(5);
        check(sda_pull_o == 1'b0 && word_o == 24'd0, "R1 after release", {8'd0, word_o}, 32'd0);

        // basic word at 0xC0
        addr_sel = 2'd0;
        bus_start();
        send_byte(8'hC0, 1'b1, "R3 addr C0");
        send_word(24'h112233);
        bus_stop();

        // two words in one transfer at 0xC4
        addr_sel = 2'd2;
        bus_start();
        send_byte(8'hC4, 1'b1, "R3 addr C4");
        send_word(24'hA5F00F);
        send_word(24'h80017E);
        bus_stop();

        // mismatched address
        bus_start();
        send_byte(8'hC2, 1'b0, "R4 wrong addr");
        send_byte(8'h12, 1'b0, "R4 byte ignored");
        send_byte(8'h34, 1'b0, "R4 byte ignored");
        send_byte(8'h56, 1'b0, "R4 byte ignored");
        bus_stop();

        // read bit set
        addr_sel = 2'd3;
        bus_start();
        send_byte(8'hC7, 1'b0, "R4 read addr");
        bus_stop();

        // partial word discarded by repeated START, also mid-byte START
        bus_start();
        send_byte(8'hC6, 1'b1, "R3 addr C6");
        send_byte(8'hDE, 1'b1, "R5");
        send_byte(8'hAD, 1'b1, "R5");
        bus_start();
        send_byte(8'hC6, 1'b1, "R2 repeated start addr");
        send_word(24'h0BEEF1);
        // START in the middle of a byte
        scl = 1'b0; hold(4);
        sda_host = 1'b1; hold(H);
        scl = 1'b1; hold(H);
        scl = 1'b0; hold(4);
        bus_start();
        send_byte(8'hC6, 1'b1, "R2 start mid-byte");
        send_byte(8'h99, 1'b1, "R7 partial");
        bus_start();
        send_byte(8'hC6, 1'b1, "R7 restart addr");
        send_word(24'h445566);
        bus_stop();

        // bytes after STOP with no new START
        send_byte(8'hC6, 1'b0, "R8 no ack after stop");
        send_byte(8'h01, 1'b0, "R8 no ack after stop");
        send_byte(8'h02, 1'b0, "R8 no ack after stop");
        send_byte(8'h03, 1'b0, "R8 no ack after stop");
        scl = 1'b1; hold(H);

        hold(50);
        check(exp_q.size() == 0, "R6 all words seen", 32'(exp_q.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule